// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into non-return-to-zero asynchronous frames on one output line. The line rests high. Each frame has these parts, in order:

- a low start bit;
- 1 to 8 data bits, least significant bit first;
- an optional multiprocessor address bit;
- an optional parity bit;
- one or two high stop bits.

The bit time comes from a shared 16-bit divisor. Each bit lasts eight times (divisor + 1) clock cycles.

Software writes a character into a single-entry holding buffer, together with a per-character address flag. The buffer passes the character to the frame sequencer as soon as the sequencer is free. A second character can therefore wait while the first is on the line. A ready flag, and an interrupt behind its own enable, show when the buffer can take a character. An empty flag shows that the line has gone quiet. Two multiprocessor conventions are offered:

- Address-bit: an extra bit in each frame marks address characters.
- Idle-line: an address character is preceded by a long idle period.

The frame configuration is sampled when a character enters the sequencer.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame sends one 0 start bit, then `char_len`+1 data bits with the least significant bit first, then stop bits at 1. There is one stop bit when `two_stop`=0 and two when `two_stop`=1.
- R3: Every bit holds `txd` for exactly (`baud_div`+1)×8 clock cycles. `txd` changes only on a bit boundary or when a frame is loaded.
- R4: `par_mode` 2'b01 selects odd parity, 2'b10 selects even parity, and 2'b00 or 2'b11 sends no parity bit. The parity bit makes the count of ones over the data bits, the address bit (if sent) and the parity bit itself odd or even.
- R5: With `mp_mode`=2'b01, one bit equal to the character's `wr_addr` flag is sent after the last data bit and before parity.
- R6: With `mp_mode`=2'b10, a character written with `wr_addr`=1 is preceded by at least 11 bit times of high line. In any other case the frame starts with no inserted gap. With `mp_mode` 2'b00 or 2'b11 there is no extra bit and no gap.
- R7: A write (`wr_valid`=1) is accepted only while `tx_ready`=1, and `tx_ready` is 0 in the cycle after an accepted write. A write while `tx_ready`=0 is ignored and changes neither the queued character nor any frame.
- R8: When the sequencer is idle, a character moves from the buffer into the sequencer one clock after it was written. At that same edge `tx_ready` returns to 1 and the start bit (or the idle-line gap) begins.
- R9: `tx_empty` is 0 from an accepted write until the last stop bit of the last queued character has ended. It is 1 only when the buffer and the sequencer are both empty.
- R10: `tx_irq` is 1 exactly when `tx_int_en`=1 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | Bit-time divisor; bit = (baud_div+1)×8 clocks |
| char_len | input | 3 | Data bits minus one |
| par_mode | input | 2 | 01 odd, 10 even, 00/11 none |
| two_stop | input | 1 | 1 selects two stop bits |
| mp_mode | input | 2 | 01 address-bit, 10 idle-line, 00/11 plain |
| tx_int_en | input | 1 | Enables the ready interrupt |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| wr_addr | input | 1 | Per-character address flag |
| txd | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | Buffer and sequencer both empty |
| tx_irq | output | 1 | Ready interrupt |

## Verification
The bench pushes a character into the queue while the previous one is still on the line, then writes a third time while the buffer is full. A design that overwrote the buffer would send the third character, and the bench's frame decoder would report an unexpected or mismatched frame. One-bit characters, odd and even parity with and without the address bit, and two stop bits are all exercised. These cases catch a sequencer that miscounts the data bits or computes parity without the address bit. The bench measures the idle-line gap and the start delay from a write to an idle sequencer, which exposes an off-by-one in the staging path. A large divisor exposes a bit timer that drops the +1 or the factor of eight.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_OFF2 = 2'b11
  } par_sel_t;

  typedef enum logic [1:0] {
    MP_PLAIN = 2'b00,
    MP_ABIT  = 2'b01,
    MP_IDLE  = 2'b10,
    MP_RSVD  = 2'b11
  } mp_sel_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GAP,
    SQ_START,
    SQ_DATA,
    SQ_ABIT,
    SQ_PAR,
    SQ_STOP
  } seq_state_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             div_wrap;

  always_comb begin
    div_wrap = (div_q >= div);
    tick     = div_wrap && (sub_q == SUB_LAST);
    div_d    = div_q;
    sub_d    = sub_q;
    if (clr) begin
      div_d = '0;
      sub_d = '0;
    end else if (div_wrap) begin
      div_d = '0;
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= div_d;
      sub_q <= sub_d;
    end
  end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              addr
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_q, addr_d;
  logic              accept;

  always_comb begin
    accept = wr_valid && !full_q;
    full_d = full_q;
    data_d = data_q;
    addr_d = addr_q;
    if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
      addr_d = wr_addr;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      addr_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        data_q <= data_d;
        addr_q <= addr_d;
      end
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign addr = addr_q;

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GAP_BITS = 11,
  parameter int LEN_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [1:0]        ld_par,
  input  logic              ld_two,
  input  logic [1:0]        ld_mp,
  input  logic              tick,
  output logic              txd,
  output logic              busy
);
  localparam int CNT_MAX = (GAP_BITS > DATA_W) ? GAP_BITS : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              txd_q, txd_d;
  logic              abit_q, abit_d;
  logic              pbit_q, pbit_d;
  logic [LEN_W-1:0]  len_q, len_d;
  par_sel_t          par_q, par_d;
  logic              two_q, two_d;
  mp_sel_t           mp_q, mp_d;

  logic [DATA_W-1:0] len_mask;
  logic              ld_xor;
  logic              par_on;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      len_mask[i] = (i <= int'(ld_len));
    end
    ld_xor = ^(ld_data & len_mask) ^ ((mp_sel_t'(ld_mp) == MP_ABIT) && ld_addr);
    par_on = (par_q == PAR_ODD) || (par_q == PAR_EVEN);
  end

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    txd_d  = txd_q;
    abit_d = abit_q;
    pbit_d = pbit_q;
    len_d  = len_q;
    par_d  = par_q;
    two_d  = two_q;
    mp_d   = mp_q;
    unique case (st_q)
      SQ_IDLE: begin
        txd_d = 1'b1;
        if (load) begin
          sh_d   = ld_data;
          abit_d = ld_addr;
          len_d  = ld_len;
          par_d  = par_sel_t'(ld_par);
          two_d  = ld_two;
          mp_d   = mp_sel_t'(ld_mp);
          pbit_d = (par_sel_t'(ld_par) == PAR_ODD) ? ~ld_xor : ld_xor;
          if ((mp_sel_t'(ld_mp) == MP_IDLE) && ld_addr) begin
            st_d  = SQ_GAP;
            cnt_d = CNT_W'(GAP_BITS - 1);
          end else begin
            st_d  = SQ_START;
            txd_d = 1'b0;
          end
        end
      end
      SQ_GAP: begin
        if (tick) begin
          if (cnt_q == '0) begin
            st_d  = SQ_START;
            txd_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      SQ_START: begin
        if (tick) begin
          st_d  = SQ_DATA;
          txd_d = sh_q[0];
          cnt_d = CNT_W'(len_q);
        end
      end
      SQ_DATA: begin
        if (tick) begin
          if (cnt_q != '0) begin
            sh_d  = sh_q >> 1;
            txd_d = sh_q[1];
            cnt_d = cnt_q - 1'b1;
          end else if (mp_q == MP_ABIT) begin
            st_d  = SQ_ABIT;
            txd_d = abit_q;
          end else if (par_on) begin
            st_d  = SQ_PAR;
            txd_d = pbit_q;
          end else begin
            st_d  = SQ_STOP;
            txd_d = 1'b1;
            cnt_d = CNT_W'(two_q);
          end
        end
      end
      SQ_ABIT: begin
        if (tick) begin
          if (par_on) begin
            st_d  = SQ_PAR;
            txd_d = pbit_q;
          end else begin
            st_d  = SQ_STOP;
            txd_d = 1'b1;
            cnt_d = CNT_W'(two_q);
          end
        end
      end
      SQ_PAR: begin
        if (tick) begin
          st_d  = SQ_STOP;
          txd_d = 1'b1;
          cnt_d = CNT_W'(two_q);
        end
      end
      SQ_STOP: begin
        if (tick) begin
          if (cnt_q == '0) begin
            st_d = SQ_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      txd_q  <= 1'b1;
      abit_q <= 1'b0;
      pbit_q <= 1'b0;
      len_q  <= '0;
      par_q  <= PAR_OFF;
      two_q  <= 1'b0;
      mp_q   <= MP_PLAIN;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      txd_q  <= txd_d;
      abit_q <= abit_d;
      pbit_q <= pbit_d;
      len_q  <= len_d;
      par_q  <= par_d;
      two_q  <= two_d;
      mp_q   <= mp_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (st_q != SQ_IDLE);

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 16,
  parameter int OVS      = 8,
  parameter int GAP_BITS = 11,
  parameter int LEN_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic [1:0]        mp_mode,
  input  logic              tx_int_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              tx_irq
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_addr;
  logic              busy;
  logic              xfer;
  logic              tick;

  assign xfer = hold_full && !busy;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_addr  (wr_addr),
    .take     (xfer),
    .full     (hold_full),
    .data     (hold_data),
    .addr     (hold_addr)
  );

  sertx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (xfer),
    .div   (baud_div),
    .tick  (tick)
  );

  sertx_seq #(.DATA_W(DATA_W), .GAP_BITS(GAP_BITS), .LEN_W(LEN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (xfer),
    .ld_data (hold_data),
    .ld_addr (hold_addr),
    .ld_len  (char_len),
    .ld_par  (par_mode),
    .ld_two  (two_stop),
    .ld_mp   (mp_mode),
    .tick    (tick),
    .txd     (txd),
    .busy    (busy)
  );

  assign tx_ready = !hold_full;
  assign tx_empty = !hold_full && !busy;
  assign tx_irq   = tx_int_en && !hold_full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic tx_irq,
  input logic tx_int_en,
  input logic wr_valid,
  input logic bit_tick,
  input logic load
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd); // R1

  AST_EDGE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick || load)); // R3

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && tx_ready && !tx_empty) |=> !tx_ready); // R7

  AST_EMPTY_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready); // R9

  AST_EMPTY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> ($past(txd) && txd)); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_int_en || !tx_ready) |-> !tx_irq); // R10

endmodule

bind sertx_core sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .tx_ready  (tx_ready),
  .tx_empty  (tx_empty),
  .tx_irq    (tx_irq),
  .tx_int_en (tx_int_en),
  .wr_valid  (wr_valid),
  .bit_tick  (tick),
  .load      (xfer)
);

// File: tb/tb_sertx_core.sv
module tb_sertx_core;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] baud_div;
  logic [2:0]  char_len;
  logic [1:0]  par_mode;
  logic        two_stop;
  logic [1:0]  mp_mode;
  logic        tx_int_en;
  logic        wr_valid;
  logic [7:0]  wr_data;
  logic        wr_addr;
  logic        txd, tx_ready, tx_empty, tx_irq;

  sertx_core dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .char_len(char_len),
    .par_mode(par_mode), .two_stop(two_stop), .mp_mode(mp_mode),
    .tx_int_en(tx_int_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_addr(wr_addr), .txd(txd), .tx_ready(tx_ready),
    .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  typedef struct {
    logic [15:0] bits;
    logic [15:0] is_par;
    logic [15:0] is_abit;
    int          n;
    int          nper;
    longint      exp_start;
    longint      min_start;
  } frame_t;

  frame_t q[$];
  int     checks = 0;
  int     errors = 0;
  int     pushed = 0;
  int     decoded = 0;
  longint cyc = 0;
  bit     finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic frame_t build(input logic [7:0] d, input logic a);
    frame_t f;
    logic   x;
    f.bits = '1; f.is_par = '0; f.is_abit = '0;
    f.n = 0; x = 1'b0;
    f.bits[0] = 1'b0; f.n = 1;
    for (int i = 0; i <= int'(char_len); i++) begin
      f.bits[f.n] = d[i]; x = x ^ d[i]; f.n++;
    end
    if (mp_mode == 2'b01) begin
      f.bits[f.n] = a; f.is_abit[f.n] = 1'b1; x = x ^ a; f.n++;
    end
    if (par_mode == 2'b01) begin
      f.bits[f.n] = ~x; f.is_par[f.n] = 1'b1; f.n++;
    end else if (par_mode == 2'b10) begin
      f.bits[f.n] = x; f.is_par[f.n] = 1'b1; f.n++;
    end
    f.bits[f.n] = 1'b1; f.n++;
    if (two_stop) begin f.bits[f.n] = 1'b1; f.n++; end
    f.nper = (int'(baud_div) + 1) * 8;
    f.exp_start = -1;
    f.min_start = 0;
    return f;
  endfunction

  // called at a negedge; write lands on the following posedge
  task automatic do_write(input logic [7:0] d, input logic a);
    frame_t f;
    longint gap;
    while (!tx_ready) @(negedge clk);
    f = build(d, a);
    gap = (mp_mode == 2'b10 && a) ? 11 * f.nper : 0;
    f.min_start = cyc + 2 + gap;
    if (tx_empty) f.exp_start = cyc + 2 + gap;
    q.push_back(f);
    pushed++;
    wr_valid = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (!(decoded == pushed && tx_empty)) @(negedge clk);
    @(negedge clk);
    chk(tx_empty === 1'b1, "R9 empty after drain", tx_empty, 1);
    chk(txd === 1'b1, "R1 line high after drain", txd, 1);
  endtask

  // frame decoder
  initial begin
    frame_t f;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        if (q.size() == 0) begin
          chk(0, "R7 unexpected frame", 1, 0);
          repeat (8) @(negedge clk);
        end else begin
          f = q.pop_front();
          if (f.exp_start >= 0)
            chk(cyc == f.exp_start, "R8 R6 start cycle", cyc, f.exp_start);
          chk(cyc >= f.min_start, "R6 idle gap length", cyc, f.min_start);
          for (int k = 0; k < f.n; k++) begin
            repeat ((k == 0) ? f.nper / 2 : f.nper) @(negedge clk);
            if (f.is_par[k])
              chk(txd === f.bits[k], "R4 parity bit", txd, f.bits[k]);
            else if (f.is_abit[k])
              chk(txd === f.bits[k], "R5 address bit", txd, f.bits[k]);
            else
              chk(txd === f.bits[k], "R2 R3 frame bit", txd, f.bits[k]);
            if (k < f.n - 1)
              chk(tx_empty === 1'b0, "R9 empty during frame", tx_empty, 0);
          end
          decoded++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 200000);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_addr = 1'b0;
    baud_div = 16'd0; char_len = 3'd7; par_mode = 2'b00; two_stop = 1'b0;
    mp_mode = 2'b00; tx_int_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(tx_ready === 1'b1, "R1 reset ready", tx_ready, 1);
    chk(tx_empty === 1'b1, "R1 reset empty", tx_empty, 1);
    chk(tx_irq === 1'b1, "R10 irq when ready", tx_irq, 1);

    // queueing and ignored write
    do_write(8'hA5, 1'b0);
    chk(tx_ready === 1'b0, "R7 ready low after write", tx_ready, 0);
    chk(tx_irq === 1'b0, "R10 irq low when full", tx_irq, 0);
    chk(tx_empty === 1'b0, "R9 empty low after write", tx_empty, 0);
    @(negedge clk);
    chk(tx_ready === 1'b1, "R8 ready back after transfer", tx_ready, 1);
    chk(txd === 1'b0, "R8 start bit after transfer", txd, 0);
    do_write(8'h3C, 1'b0);
    chk(tx_ready === 1'b0, "R7 second char queued", tx_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hFF; wr_addr = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(tx_ready === 1'b0, "R7 write while full ignored", tx_ready, 0);
    drain();

    tx_int_en = 1'b0;
    @(negedge clk);
    chk(tx_irq === 1'b0, "R10 irq masked", tx_irq, 0);
    tx_int_en = 1'b1;

    // one-bit characters, odd parity, two stops
    baud_div = 16'd1; char_len = 3'd0; par_mode = 2'b01; two_stop = 1'b1;
    do_write(8'h01, 1'b0); do_write(8'h00, 1'b0); drain();
    // five bits, even parity
    char_len = 3'd4; par_mode = 2'b10; two_stop = 1'b0;
    do_write(8'hFF, 1'b0); do_write(8'h12, 1'b0); drain();
    // address-bit mode with parity
    mp_mode = 2'b01;
    do_write(8'h0B, 1'b1); do_write(8'h0B, 1'b0); drain();
    par_mode = 2'b01;
    do_write(8'h07, 1'b1); drain();
    // idle-line mode
    baud_div = 16'd0; mp_mode = 2'b10; par_mode = 2'b00; char_len = 3'd7;
    do_write(8'h81, 1'b1); drain();
    do_write(8'h42, 1'b0); drain();
    do_write(8'h55, 1'b0); do_write(8'hAA, 1'b1); drain();
    // large divisor
    mp_mode = 2'b00; baud_div = 16'd300;
    do_write(8'hC3, 1'b0); drain();

    // random rounds
    for (int r = 0; r < 25; r++) begin
      baud_div = 16'($urandom_range(0, 3));
      char_len = 3'($urandom_range(0, 7));
      par_mode = 2'($urandom_range(0, 3));
      two_stop = 1'($urandom_range(0, 1));
      mp_mode  = 2'($urandom_range(0, 3));
      do_write(8'($urandom), 1'($urandom_range(0, 1)));
      do_write(8'($urandom), 1'($urandom_range(0, 1)));
      drain();
    end

    chk(q.size() == 0, "R2 all frames seen", q.size(), 0);
    summary();
  end

endmodule